// File: doc/BRIEF.md
# Bidirectional Logical Barrel Shifter

This block shifts an 8-bit data word left or right by 0 to 7 bit positions in a single combinational pass. It has no clock, state or reset. A 3-bit unsigned amount sets the distance. A direction bit sets the sense of the shift. Bits that are shifted out are lost, and every vacated position is filled with zero.

The datapath uses only two-input multiplexer cells. A right-shifting barrel has one stage per bit of the amount, and the stages move the word by 1, 2 and 4 places. For left shifts, a rank of multiplexers mirrors the word before the barrel, and a second rank mirrors the result after it. One barrel therefore serves both directions.

Top module: `bidir_barrel_shifter`

## Requirements
- R1: With `dir_left` = 0, `dout` equals `din` logically shifted right by `amt` places, and bits leave at the low end.
- R2: With `dir_left` = 1, `dout` equals `din` logically shifted left by `amt` places, and bits leave at the high end.
- R3: Vacated positions are always zero. For a right shift, the top `amt` bits of `dout` are 0. For a left shift, the bottom `amt` bits are 0.
- R4: With `amt` = 0, `dout` equals `din` in both directions.
- R5: At the largest amount (7), exactly one input bit survives. A right shift places `din[7]` in `dout[0]`. A left shift places `din[0]` in `dout[7]`. Every other output bit is zero.
- R6: `dout` is a purely combinational function of the present inputs. It follows any input change with no clock edge and depends on no earlier input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Data word to shift |
| amt | input | 3 | Shift distance, unsigned, 0 to 7 |
| dir_left | input | 1 | 1 = shift toward the MSB, 0 = shift toward the LSB |
| dout | output | 8 | Shifted word |

## Verification
The bench targets the following corner cases:
- **Zero shift in each direction:** a design that mirrored the word but did not restore it would return the input reversed.
- **Maximum shift of 7 with a single lone bit:** a design that wired the 4-place stage with the wrong offset would lose the bit or place it at the wrong end.
- **All-ones words:** these expose vacated positions that are filled with ones or with wrapped bits instead of zeros, which would turn the logical shift into a rotate or an arithmetic shift.
- **Every combination of word, amount and direction against the native operators:** this catches a stage enabled by the wrong amount bit, and a direction bit with its sense inverted.

// File: rtl/bshift_pkg.sv
// Package: shared widths and types for the bidirectional barrel shifter.
// Assumes the data width is a power of two so that the amount width is exact.
package bshift_pkg;
    localparam int DATA_W = 8;
    localparam int AMT_W  = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [AMT_W-1:0]  amt_t;
endpackage

// File: rtl/bshift_mux2.sv
// Module: bshift_mux2
// The single-bit two-input selector that is the only logic cell of the shifter.
// Assumes sel is a clean 0/1; out follows b when sel is 1, a otherwise.
module bshift_mux2 (
    input  logic a,
    input  logic b,
    input  logic sel,
    output logic y
);
    // Purpose: choose between the two data inputs.
    always_comb begin
        y = sel ? b : a;
    end
endmodule

// File: rtl/bshift_mirror.sv
// Module: bshift_mirror
// Optionally reverses the bit order of a word through one rank of 2:1 muxes.
// Assumes WIDTH >= 2; when en is 0 the word passes straight through.
module bshift_mirror #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_w,
    input  logic             en,
    output logic [WIDTH-1:0] out_w
);
    // One selector per bit: straight bit or its mirror partner.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bshift_mux2 u_mux (
            .a   (in_w[i]),
            .b   (in_w[WIDTH-1-i]),
            .sel (en),
            .y   (out_w[i])
        );
    end

    // Purpose: guard mirror behaviour at the extreme bits.
    always_comb begin
        if (!$isunknown({in_w, en})) begin
            p_mirror_ends_r2: assert (en ? (out_w[0] == in_w[WIDTH-1] && out_w[WIDTH-1] == in_w[0])
                                         : (out_w == in_w))
                else $error("mirror rank misrouted its end bits");
        end
    end
endmodule

// File: rtl/bshift_stage.sv
// Module: bshift_stage
// One barrel stage: shifts a word toward the LSB by DIST places when en is 1.
// Assumes 0 < DIST < WIDTH; bits entering from the top are tied to zero.
module bshift_stage #(
    parameter int WIDTH = 8,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] in_w,
    input  logic             en,
    output logic [WIDTH-1:0] out_w
);
    // Per-bit selector: hold the bit, or take the one DIST places higher (or zero).
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i + DIST < WIDTH) begin : g_move
            bshift_mux2 u_mux (
                .a   (in_w[i]),
                .b   (in_w[i+DIST]),
                .sel (en),
                .y   (out_w[i])
            );
        end else begin : g_fill
            bshift_mux2 u_mux (
                .a   (in_w[i]),
                .b   (1'b0),
                .sel (en),
                .y   (out_w[i])
            );
        end
    end

    // Purpose: an idle stage is transparent, an active one clears its top DIST bits.
    always_comb begin
        if (!$isunknown({in_w, en})) begin
            p_idle_pass_r4: assert (en || out_w == in_w)
                else $error("idle stage altered its word");
            p_top_clear_r3: assert (!en || out_w[WIDTH-1] == 1'b0)
                else $error("active stage left a nonzero fill bit");
        end
    end
endmodule

// File: rtl/bidir_barrel_shifter.sv
// Module: bidir_barrel_shifter
// Combinational logical shifter, left or right by 0..DATA_W-1 places.
// Left shifts reuse the right-shift barrel between two mirror ranks.
// Assumes no clock or reset; the output depends only on the present inputs.
module bidir_barrel_shifter
    import bshift_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  logic              dir_left,
    output logic [DATA_W-1:0] dout
);
    word_t mirror_in;
    word_t stage_w [AMT_W+1];

    // Entry mirror: reverse the word for left shifts.
    bshift_mirror #(.WIDTH(DATA_W)) u_mirror_in (
        .in_w  (din),
        .en    (dir_left),
        .out_w (mirror_in)
    );

    assign stage_w[0] = mirror_in;

    // Barrel: stage k moves by 2**k places under amount bit k.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        bshift_stage #(.WIDTH(DATA_W), .DIST(1 << k)) u_stage (
            .in_w  (stage_w[k]),
            .en    (amt[k]),
            .out_w (stage_w[k+1])
        );
    end

    // Exit mirror: restore the bit order for left shifts.
    bshift_mirror #(.WIDTH(DATA_W)) u_mirror_out (
        .in_w  (stage_w[AMT_W]),
        .en    (dir_left),
        .out_w (dout)
    );

    // Purpose: port-level checks of fill, pass-through, and the extreme amount.
    always_comb begin
        if (!$isunknown({din, amt, dir_left})) begin
            p_zero_pass_r4: assert (amt != '0 || dout == din)
                else $error("zero amount changed the word");
            p_low_fill_r3: assert (!(dir_left && amt != '0) || dout[0] == 1'b0)
                else $error("left shift left a nonzero LSB");
            p_high_fill_r3: assert (!(!dir_left && amt != '0) || dout[DATA_W-1] == 1'b0)
                else $error("right shift left a nonzero MSB");
            p_no_gain_r1: assert ($countones(dout) <= $countones(din))
                else $error("shift created extra set bits");
            p_max_right_r5: assert (!(!dir_left && amt == AMT_W'(DATA_W-1))
                                    || dout == {{(DATA_W-1){1'b0}}, din[DATA_W-1]})
                else $error("maximum right shift misplaced the surviving bit");
        end
    end
endmodule

// File: tb/bidir_barrel_shifter_tb.sv
// Bench: table of directed vectors, then an exhaustive sweep against native operators.
module bidir_barrel_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic [2:0] amt = '0;
    logic       dir_left = 1'b0;
    logic [7:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    bidir_barrel_shifter dut_i (
        .din      (din),
        .amt      (amt),
        .dir_left (dir_left),
        .dout     (dout)
    );

    // 100 MHz clock, used only to pace the watchdog.
    always #5 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Entry fields: {req[3:0], dir_left, amt[2:0], din[7:0], expected[7:0]}
    localparam logic [23:0] VEC [16] = '{
        24'h40A5A5,  // R4 right, zero amount
        24'h48A5A5,  // R4 left, zero amount
        24'h11A552,  // R1 right by 1
        24'h29A54A,  // R2 left by 1
        24'h578001,  // R5 right by 7, lone MSB survives
        24'h5F0180,  // R5 left by 7, lone LSB survives
        24'h577F00,  // R5 right by 7, MSB clear
        24'h5FFE00,  // R5 left by 7, LSB clear
        24'h34FF0F,  // R3 right by 4, zeros fill top
        24'h3CFFF0,  // R3 left by 4, zeros fill bottom
        24'h139612,  // R1 right by 3
        24'h2B96B0,  // R2 left by 3
        24'h12C330,  // R1 right by 2
        24'h2AC30C,  // R2 left by 2
        24'h3DFFE0,  // R3 left by 5
        24'h36FF03   // R3 right by 6
    };

    task automatic check(input string req, input logic [7:0] exp_v);
        n_cmp++;
        if (dout !== exp_v) begin
            n_bad++;
            $display("FAIL %s: din=%h amt=%0d dir_left=%0b got %h expected %h",
                     req, din, amt, dir_left, dout, exp_v);
        end
    endtask

    initial begin
        // Reset phase: all-zero inputs must give an all-zero word.
        #2;
        check("R4", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        foreach (VEC[i]) begin
            dir_left = VEC[i][19];
            amt      = VEC[i][18:16];
            din      = VEC[i][15:8];
            #2;
            check($sformatf("R%0d", VEC[i][23:20]), VEC[i][7:0]);
        end

        // R6: output follows an input change with no clock edge in between.
        @(negedge clk);
        din = 8'h3C; amt = 3'd1; dir_left = 1'b0;
        #1;
        check("R6", 8'h1E);
        dir_left = 1'b1;
        #1;
        check("R6", 8'h78);
        din = 8'hC0;
        #1;
        check("R6", 8'h80);

        // Exhaustive sweep: R1 right, R2 left, R3 fill follows from operators.
        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < 8; a++) begin
                for (int w = 0; w < 256; w++) begin
                    dir_left = d[0];
                    amt      = a[2:0];
                    din      = w[7:0];
                    #2;
                    if (d == 1) check("R2", din << a);
                    else        check("R1", din >> a);
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule